// File: doc/BRIEF.md
# Forward Discrete Periodic Radon Engine

This block computes the forward discrete periodic Radon transform of a square image whose side N is a small prime number. Pixels are unsigned integers of B bits. After a start pulse the image arrives one row per accepted cycle, and each row is held in its own circular register. From then on the engine produces one complete projection on every clock cycle. A bank of N pipelined integer adder trees sums N aligned pixels per tree. Each row register rotates by its own row number between projections, so no pixel is ever addressed.

The engine streams N+1 projections in a fixed order. Projections 0 to N-1 are the slanted sums. Projection N holds the row sums, taken from the same trees through a transposed read of the row registers. Every projection carries a valid flag and its index. Sums are wide enough that no input image can overflow them.

Top module: `dprt_fwd_engine`

## Requirements
- R1: Each output sum is B + ceil(log2 N) bits wide and holds the exact sum with no overflow, including when every pixel is at its maximum value 2^B-1.
- R2: A start pulse is accepted only while busy is low and begins a new load. A start pulse while busy is high has no effect on the load, the projections or their order.
- R3: While loading, a row is taken only in cycles with in_valid high, and the N accepted rows are assigned to image rows 0..N-1 in arrival order. Idle cycles may fall between rows. An in_valid pulse while the engine is idle does not start the engine or produce output.
- R4: In in_row, pixel column j sits at bits [j*B +: B]. For projection index m < N, out_data bits [d*SW +: SW] (SW = B + ceil(log2 N)) equal the sum over rows i of pixel(i, (d + m*i) mod N).
- R5: For projection index N, out_data slot d equals the sum of all pixels in row d.
- R6: Each run emits exactly N+1 projections on consecutive cycles, with out_m counting 0, 1, ..., N. out_valid is low at all other times.
- R7: The projection with out_m = 0 appears with out_valid high exactly L rising edges after the edge that accepts the last row, with L = ceil(log2 N). Projection m follows m cycles later.
- R8: After reset, busy and out_valid are low. Busy is high from the edge that accepts start until the last projection has entered the adder trees, and it is low by the time that projection leaves the trees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin loading a new image (taken only when idle) |
| busy | output | 1 | High while loading or issuing projections |
| in_valid | input | 1 | in_row carries the next image row |
| in_row | input | N*B | One image row, column j at bits [j*B +: B] |
| out_valid | output | 1 | out_m and out_data carry a projection |
| out_m | output | clog2(N+1) | Projection index, 0..N |
| out_data | output | N*(B+clog2 N) | N sums, slot d at bits [d*SW +: SW] |

## Verification
The hardest case to reach from the ports is a load that has idle cycles between rows and start pulses arriving while the engine is already loading or issuing. Either one would corrupt the row order or the projection order without any visible sign. Selected runs in the stimulus table therefore insert an idle cycle in the middle of the load and raise start both with the first row and during the first issue cycle. Every projection is then compared against sums computed in the bench with modular indexing, on the exact cycle they are due. An all-maximum image pushes every tree to its largest possible sum.

// File: rtl/dprt_pkg.sv
// Package: shared types for the forward periodic Radon engine.
// Assumes: nothing beyond the parameters passed to each module.
package dprt_pkg;

    // Sequencing states of the controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } dprt_state_e;

endpackage

// File: rtl/dprt_ctrl.sv
// Controller: accepts start when idle, counts N loaded rows, then issues
// projection steps 0..N on consecutive cycles. It rotates the row array
// after each slanted step and selects the transposed read for step N.
// Assumes: N >= 2.
module dprt_ctrl
    import dprt_pkg::*;
#(
    parameter int N = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   in_valid,
    output logic                   busy,
    output logic                   load_en,
    output logic [$clog2(N)-1:0]   load_idx,
    output logic                   issue_valid,
    output logic [$clog2(N+1)-1:0] issue_m,
    output logic                   rot_en,
    output logic                   transpose
);
    localparam int IW = $clog2(N);
    localparam int MW = $clog2(N+1);

    dprt_state_e   state_q;
    logic [MW-1:0] cnt_q;
    logic [MW-1:0] step_q;

    // Purpose: state, row counter and step counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LOAD;
                        cnt_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == MW'(N-1)) begin
                            state_q <= ST_RUN;
                            step_q  <= '0;
                        end
                    end
                end
                ST_RUN: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == MW'(N)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode control strobes from the current state.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        load_en     = (state_q == ST_LOAD) && in_valid;
        load_idx    = cnt_q[IW-1:0];
        issue_valid = (state_q == ST_RUN);
        issue_m     = step_q;
        rot_en      = (state_q == ST_RUN) && (step_q != MW'(N));
        transpose   = (state_q == ST_RUN) && (step_q == MW'(N));
    end

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_LOAD && cnt_q == '0)); // R2
    AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && in_valid && cnt_q == MW'(N-1)) |=> (state_q == ST_RUN && step_q == '0)); // R3
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !in_valid) |=> (state_q == ST_LOAD && $stable(cnt_q))); // R3
    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step_q != MW'(N)) |=> (state_q == ST_RUN && step_q == $past(step_q) + 1'b1)); // R6

endmodule

// File: rtl/dprt_row_array.sv
// Row array: N circular registers of N pixels each. A load writes one
// whole row. A rotate moves row i left by i pixel positions, so slot d of
// row i then holds the pixel that slanted step m needs. Tree d reads
// column d in normal mode and row d in transposed mode.
// Assumes: load and rotate never address the same row in one cycle.
module dprt_row_array #(
    parameter int N = 5,
    parameter int B = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [$clog2(N)-1:0] load_idx,
    input  logic [N*B-1:0]       in_row,
    input  logic                 rot_en,
    input  logic                 transpose,
    output logic [N*N*B-1:0]     tree_in
);
    localparam int RW = N * B;

    logic [RW-1:0] row_q [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        // Purpose: load row i or rotate it left by i pixels.
        always_ff @(posedge clk) begin
            if (load_en && load_idx == ($clog2(N))'(i)) begin
                row_q[i] <= in_row;
            end else if (rot_en) begin
                for (int j = 0; j < N; j++) begin
                    row_q[i][j*B +: B] <= row_q[i][((j + i) % N)*B +: B];
                end
            end
        end
    end

    // Purpose: route column d (or row d when transposed) to tree d.
    always_comb begin
        for (int d = 0; d < N; d++) begin
            for (int i = 0; i < N; i++) begin
                tree_in[(d*N + i)*B +: B] = transpose ? row_q[d][i*B +: B]
                                                      : row_q[i][d*B +: B];
            end
        end
    end

    AST_ROW0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && !(load_en && load_idx == '0)) |=> $stable(row_q[0])); // R4

endmodule

// File: rtl/dprt_adder_tree.sv
// Adder tree: sums N unsigned B-bit inputs in ceil(log2 N) registered
// levels of pairwise adds. Missing leaves are zero.
// Assumes: N >= 2 and SW >= B + ceil(log2 N).
module dprt_adder_tree #(
    parameter int N  = 5,
    parameter int B  = 8,
    parameter int SW = 11
) (
    input  logic           clk,
    input  logic [N*B-1:0] leaf_in,
    output logic [SW-1:0]  sum_out
);
    localparam int L = $clog2(N);
    localparam int P = 1 << L;
    localparam int H = P / 2;

    logic [SW-1:0] leaf [P];
    logic [SW-1:0] lvl_q [L][H];

    // Purpose: widen the leaves and pad the tree to a power of two.
    always_comb begin
        for (int j = 0; j < P; j++) begin
            leaf[j] = (j < N) ? {{(SW-B){1'b0}}, leaf_in[(j % N)*B +: B]} : '0;
        end
    end

    // Purpose: one registered level of pairwise sums per stage.
    always_ff @(posedge clk) begin
        for (int j = 0; j < H; j++) begin
            lvl_q[0][j] <= leaf[2*j] + leaf[2*j + 1];
        end
        for (int k = 1; k < L; k++) begin
            for (int j = 0; j < H; j++) begin
                if (j < (P >> (k + 1))) begin
                    lvl_q[k][j] <= lvl_q[k-1][(2*j) & (H-1)] + lvl_q[k-1][(2*j + 1) & (H-1)];
                end else begin
                    lvl_q[k][j] <= '0;
                end
            end
        end
    end

    assign sum_out = lvl_q[L-1][0];

endmodule

// File: rtl/dprt_fwd_engine.sv
// Top: forward periodic Radon engine. It wires the controller, the row
// array and N adder trees, and delays the issue tags so they arrive with
// the sums.
// Assumes: N is prime and N >= 2. Output slot d is tree d.
module dprt_fwd_engine #(
    parameter int N = 5,
    parameter int B = 8,
    localparam int SW = B + $clog2(N),
    localparam int MW = $clog2(N+1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    input  logic            in_valid,
    input  logic [N*B-1:0]  in_row,
    output logic            out_valid,
    output logic [MW-1:0]   out_m,
    output logic [N*SW-1:0] out_data
);
    localparam int L  = $clog2(N);
    localparam int IW = $clog2(N);

    logic          load_en;
    logic [IW-1:0] load_idx;
    logic          issue_valid;
    logic [MW-1:0] issue_m;
    logic          rot_en;
    logic          transpose;
    logic [N*N*B-1:0] tree_in;
    logic [L-1:0]  vld_q;
    logic [MW-1:0] tag_q [L];

    dprt_ctrl #(.N(N)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_valid    (in_valid),
        .busy        (busy),
        .load_en     (load_en),
        .load_idx    (load_idx),
        .issue_valid (issue_valid),
        .issue_m     (issue_m),
        .rot_en      (rot_en),
        .transpose   (transpose)
    );

    dprt_row_array #(.N(N), .B(B)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .in_row    (in_row),
        .rot_en    (rot_en),
        .transpose (transpose),
        .tree_in   (tree_in)
    );

    for (genvar d = 0; d < N; d++) begin : g_tree
        dprt_adder_tree #(.N(N), .B(B), .SW(SW)) u_tree (
            .clk     (clk),
            .leaf_in (tree_in[d*N*B +: N*B]),
            .sum_out (out_data[d*SW +: SW])
        );
    end

    // Purpose: delay valid and index to match the adder tree latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= issue_valid;
            for (int k = 1; k < L; k++) vld_q[k] <= vld_q[k-1];
        end
        tag_q[0] <= issue_m;
        for (int k = 1; k < L; k++) tag_q[k] <= tag_q[k-1];
    end

    assign out_valid = vld_q[L-1];
    assign out_m     = tag_q[L-1];

    AST_OUT_M_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_m <= MW'(N))); // R6
    AST_M_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_m != '0) |-> ($past(out_valid) && out_m == $past(out_m) + 1'b1)); // R6

endmodule

// File: tb/dprt_fwd_engine_tb_top.sv
// Bench: walks a table of image patterns, compares each projection with
// reference sums computed here, then runs directed reset and idle checks.
module dprt_fwd_engine_tb_top;
    localparam int N  = 5;
    localparam int B  = 8;
    localparam int SW = B + $clog2(N);
    localparam int MW = $clog2(N+1);
    localparam int L  = $clog2(N);
    localparam int NPAT = 5;
    // pattern columns: a, b, e, c, gap ; pixel = (a*i + b*j + e*i*j + c) mod 2^B
    localparam int PAT [NPAT][5] = '{
        '{1, 2, 0, 3, 0},
        '{7, 0, 3, 11, 1},
        '{0, 0, 0, 255, 0},
        '{37, 91, 13, 200, 1},
        '{0, 1, 5, 0, 0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            busy;
    logic            in_valid = 1'b0;
    logic [N*B-1:0]  in_row = '0;
    logic            out_valid;
    logic [MW-1:0]   out_m;
    logic [N*SW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int img [N][N];

    always #2 clk = ~clk;

    dprt_fwd_engine #(.N(N), .B(B)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .in_valid  (in_valid),
        .in_row    (in_row),
        .out_valid (out_valid),
        .out_m     (out_m),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [N*SW-1:0] act,
                         input logic [N*SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*SW-1:0] ref_proj(input int m);
        logic [N*SW-1:0] v = '0;
        for (int d = 0; d < N; d++) begin
            int s = 0;
            for (int i = 0; i < N; i++) begin
                if (m < N) s += img[i][(d + m*i) % N];
                else       s += img[d][i];
            end
            v[d*SW +: SW] = SW'(s);
        end
        return v;
    endfunction

    task automatic run_pattern(input int p);
        bit gap = (PAT[p][4] != 0);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                img[i][j] = (PAT[p][0]*i + PAT[p][1]*j + PAT[p][2]*i*j + PAT[p][3]) % (1 << B);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", {{(N*SW-1){1'b0}}, busy}, 1);
        for (int r = 0; r < N; r++) begin
            if (gap && r == 2) begin
                in_valid = 1'b0;
                in_row   = {(N*B){1'b1}};
                @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            for (int j = 0; j < N; j++) in_row[j*B +: B] = B'(img[r][j]);
            if (gap && r == 0) start = 1'b1;   // R2: ignored while loading
            @(posedge clk); @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        for (int k = 1; k <= L + N + 4; k++) begin
            bit due = (k >= L + 1) && (k <= L + 1 + N);
            int m = k - L - 1;
            if (gap && k == 1) start = 1'b1;   // R2: ignored while issuing
            check(out_valid == due, "R7 valid timing", {{(N*SW-1){1'b0}}, out_valid},
                  {{(N*SW-1){1'b0}}, due});
            if (due && out_valid) begin
                logic [N*SW-1:0] e = ref_proj(m);
                check(int'(out_m) == m, "R6 projection index", N*SW'(out_m), N*SW'(m));
                if (m < N) check(out_data == e, "R4 slanted sums", out_data, e);
                else       check(out_data == e, "R5 row sums", out_data, e);
                if (m == N) check(busy == 1'b0, "R8 busy low at end", N*SW'(busy), 0);
            end
            @(posedge clk); @(negedge clk);
            start = 1'b0;
        end
        check(busy == 1'b0, "R2 no restart from ignored start", N*SW'(busy), 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && busy == 1'b0, "R8 reset state",
              N*SW'({out_valid, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: in_valid while idle neither starts the engine nor makes output
        in_valid = 1'b1;
        in_row   = {(N*B){1'b1}};
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); @(negedge clk);
            check(busy == 1'b0 && out_valid == 1'b0, "R3 idle in_valid ignored",
                  N*SW'({busy, out_valid}), 0);
        end
        in_valid = 1'b0;
        for (int p = 0; p < NPAT; p++) run_pattern(p);
        // R1: all-maximum image gives the largest sum without overflow
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = (1 << B) - 1;
        check(ref_proj(0)[SW-1:0] == SW'(N * ((1 << B) - 1)), "R1 sum width",
              ref_proj(0), N*SW'(N * ((1 << B) - 1)));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule